// File: doc/BRIEF.md
# MII Carrier, Collision and Nibble Port

This block is the PHY-side end of a 10/100 Media Independent Interface. On receive, a simple line-side model offers bytes one at a time. The block splits each byte into two nibbles and drives them to the MAC on `rxd`, with a data-valid flag and an error flag. On transmit, it samples the MAC's nibbles, the transmit enable and the transmit error input. It rebuilds each pair of nibbles into a byte and hands that byte to the line side with a one-clock strobe.

Carrier sense and collision are derived from transmit and receive activity, and the rules depend on the duplex input. One nibble-rate enable stands in for both nibble clocks. In 10 Mb/s mode, one nibble moves for every `SLOW_DIV` enables. In 100 Mb/s mode, a nibble moves on every enable.

Until power-on reset has finished, every MII output and the line transmit path stay isolated. The reset window lasts `HOLD_TICKS` enable pulses after `rst_n` rises. This lets the interface be hot-inserted.

Top module: `mii_port_top`

## Requirements
- R1: After `rst_n` rises, `miiOe` and `lineTxEn` stay 0 for the first `HOLD_TICKS` (default 8) `nibEn` pulses, then go to 1. While they are 0, `rxd`, `rxDv`, `rxEr`, `crs`, `col` and `lineTxValid` read 0 whatever the inputs do.
- R2: A received byte leaves on `rxd` as two nibbles, bits [3:0] first and then bits [7:4]. `rxDv` rises with the first nibble of a frame and falls on the nibble slot after the last byte's high nibble, when no further byte is offered.
- R3: When the line model flags a byte with `lineRxErr`, `rxEr` is 1 for both nibbles of that byte and 0 for the nibbles of clean bytes.
- R4: While `txEn` is 1, two sampled nibbles form one byte: the first nibble becomes bits [3:0] and the second becomes bits [7:4]. The byte appears on `lineTxByte` with `lineTxValid` high for one clock, after the edge that samples the second nibble.
- R5: If `txEr` is 1 on either sampled nibble of a byte, `lineTxErr` is 1 for that byte. Otherwise it is 0.
- R6: With `fullDuplex` = 0, `crs` is 1 while transmit or receive is active.
- R7: With `fullDuplex` = 0, `col` is 1 exactly while receive activity overlaps transmit activity.
- R8: With `fullDuplex` = 1, `crs` follows receive activity only, and transmit has no effect on it.
- R9: With `fullDuplex` = 1, `col` stays 0.
- R10: With `speed100` = 1, a nibble moves on every `nibEn` pulse. With `speed100` = 0, a nibble moves once every `SLOW_DIV` (default 10) pulses, so the first receive nibble appears after the 10th pulse and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| nibEn | input | 1 | Nibble-rate clock enable |
| speed100 | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| fullDuplex | input | 1 | 1 selects full-duplex carrier and collision rules |
| lineRxValid | input | 1 | Line model offers a receive byte |
| lineRxByte | input | 8 | Offered receive byte |
| lineRxErr | input | 1 | Offered byte is errored |
| lineRxTake | output | 1 | Offered byte is consumed at this clock edge |
| rxd | output | 4 | Receive nibble to the MAC |
| rxDv | output | 1 | Receive data valid |
| rxEr | output | 1 | Receive error |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision detect |
| miiOe | output | 1 | MII output enable (0 = isolated) |
| txd | input | 4 | Transmit nibble from the MAC |
| txEn | input | 1 | Transmit enable |
| txEr | input | 1 | Transmit error |
| lineTxEn | output | 1 | Line transmit output enable |
| lineTxValid | output | 1 | One-clock strobe for a rebuilt transmit byte |
| lineTxByte | output | 8 | Rebuilt transmit byte |
| lineTxErr | output | 1 | Rebuilt byte carries a transmit error |

## Verification
A wrong nibble phase swaps halves on `rxd` or `lineTxByte`. The swap shows within two nibble slots of the first byte, and every byte after that stays misaligned. A stale transmit-activity register shows as `crs` or `col` lagging or overhanging a duplex change by one slot. The overlap vectors catch this in both modes. A wrong reset-window count shows as `miiOe` rising one pulse early or late, or as activity leaking onto `crs` or `rxDv` inside the window. The divider check catches a wrong 10 Mb/s divide on the first received nibble.

// File: rtl/mii_port_pkg.sv
package mii_port_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic tick;   // one nibble slot moves this clock
    logic live;   // reset window over, outputs enabled
  } portStrobe_t;
endpackage

// File: rtl/mii_port_ctrl.sv
module mii_port_ctrl
  import mii_port_pkg::*;
#(
  parameter int HOLD_TICKS = 8,
  parameter int SLOW_DIV   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nibEn,
  input  logic        speed100,
  output portStrobe_t strobe
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int DW = $clog2(SLOW_DIV + 1);

  logic [HW-1:0] holdCnt;
  logic          live;
  logic [DW-1:0] divCnt;
  logic          slowHit;

  // reset-release window: count enable pulses before going live
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdCnt <= '0;
      live    <= 1'b0;
    end else if (!live && nibEn) begin
      if (holdCnt == HW'(HOLD_TICKS - 1)) live <= 1'b1;
      else                                holdCnt <= holdCnt + 1'b1;
    end
  end

  // 10 Mb/s divider, parked at zero in 100 Mb/s mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
    end else if (!live || speed100) begin
      divCnt <= '0;
    end else if (nibEn) begin
      divCnt <= slowHit ? '0 : divCnt + 1'b1;
    end
  end

  assign slowHit = (divCnt == DW'(SLOW_DIV - 1));

  always_comb begin
    strobe.live = live;
    strobe.tick = live & nibEn & (speed100 | slowHit);
  end
endmodule

// File: rtl/mii_port_dp.sv
module mii_port_dp
  import mii_port_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  portStrobe_t          strobe,
  input  logic                 fullDuplex,
  input  logic                 lineRxValid,
  input  logic [2*NIB_W-1:0]   lineRxByte,
  input  logic                 lineRxErr,
  output logic                 lineRxTake,
  output logic [NIB_W-1:0]     rxd,
  output logic                 rxDv,
  output logic                 rxEr,
  output logic                 crs,
  output logic                 col,
  input  logic [NIB_W-1:0]     txd,
  input  logic                 txEn,
  input  logic                 txEr,
  output logic                 lineTxValid,
  output logic [2*NIB_W-1:0]   lineTxByte,
  output logic                 lineTxErr
);
  localparam int BYTE_W = 2 * NIB_W;

  logic             rxPhase;
  logic [NIB_W-1:0] rxHigh;
  logic             rxHeldErr;
  logic             txPhase;
  logic             txAct;
  logic [NIB_W-1:0] txLow;
  logic             txErrAcc;

  // receive: byte -> low nibble, then high nibble
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxPhase <= 1'b0; rxHigh <= '0; rxHeldErr <= 1'b0;
      rxd <= '0; rxDv <= 1'b0; rxEr <= 1'b0;
    end else if (!strobe.live) begin
      rxPhase <= 1'b0; rxHigh <= '0; rxHeldErr <= 1'b0;
      rxd <= '0; rxDv <= 1'b0; rxEr <= 1'b0;
    end else if (strobe.tick) begin
      if (!rxPhase) begin
        if (lineRxValid) begin
          rxd       <= lineRxByte[NIB_W-1:0];
          rxHigh    <= lineRxByte[BYTE_W-1:NIB_W];
          rxEr      <= lineRxErr;
          rxHeldErr <= lineRxErr;
          rxDv      <= 1'b1;
          rxPhase   <= 1'b1;
        end else begin
          rxd  <= '0;
          rxEr <= 1'b0;
          rxDv <= 1'b0;
        end
      end else begin
        rxd     <= rxHigh;
        rxEr    <= rxHeldErr;
        rxPhase <= 1'b0;
      end
    end
  end

  assign lineRxTake = strobe.tick & ~rxPhase & lineRxValid;

  // transmit: two nibbles -> one byte, strobe for one clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txPhase <= 1'b0; txAct <= 1'b0; txLow <= '0; txErrAcc <= 1'b0;
      lineTxValid <= 1'b0; lineTxByte <= '0; lineTxErr <= 1'b0;
    end else if (!strobe.live) begin
      txPhase <= 1'b0; txAct <= 1'b0; txLow <= '0; txErrAcc <= 1'b0;
      lineTxValid <= 1'b0; lineTxByte <= '0; lineTxErr <= 1'b0;
    end else begin
      lineTxValid <= 1'b0;
      if (strobe.tick) begin
        txAct <= txEn;
        if (txEn) begin
          if (!txPhase) begin
            txLow    <= txd;
            txErrAcc <= txEr;
            txPhase  <= 1'b1;
          end else begin
            lineTxByte  <= {txd, txLow};
            lineTxErr   <= txErrAcc | txEr;
            lineTxValid <= 1'b1;
            txPhase     <= 1'b0;
          end
        end else begin
          txPhase <= 1'b0;
        end
      end
    end
  end

  // duplex-dependent carrier and collision
  always_comb begin
    crs = rxDv | (~fullDuplex & txAct);
    col = ~fullDuplex & txAct & rxDv;
  end
endmodule

// File: rtl/mii_port_top.sv
module mii_port_top
  import mii_port_pkg::*;
#(
  parameter int HOLD_TICKS = 8,
  parameter int SLOW_DIV   = 10,
  parameter int NIB_W      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nibEn,
  input  logic               speed100,
  input  logic               fullDuplex,
  input  logic               lineRxValid,
  input  logic [2*NIB_W-1:0] lineRxByte,
  input  logic               lineRxErr,
  output logic               lineRxTake,
  output logic [NIB_W-1:0]   rxd,
  output logic               rxDv,
  output logic               rxEr,
  output logic               crs,
  output logic               col,
  output logic               miiOe,
  input  logic [NIB_W-1:0]   txd,
  input  logic               txEn,
  input  logic               txEr,
  output logic               lineTxEn,
  output logic               lineTxValid,
  output logic [2*NIB_W-1:0] lineTxByte,
  output logic               lineTxErr
);
  portStrobe_t        strobe;
  logic               dpTake, dpDv, dpEr, dpCrs, dpCol, dpTxValid, dpTxErr;
  logic [NIB_W-1:0]   dpRxd;
  logic [2*NIB_W-1:0] dpTxByte;

  mii_port_ctrl #(.HOLD_TICKS(HOLD_TICKS), .SLOW_DIV(SLOW_DIV)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .nibEn(nibEn), .speed100(speed100), .strobe(strobe)
  );

  mii_port_dp #(.NIB_W(NIB_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .fullDuplex(fullDuplex),
    .lineRxValid(lineRxValid), .lineRxByte(lineRxByte), .lineRxErr(lineRxErr),
    .lineRxTake(dpTake), .rxd(dpRxd), .rxDv(dpDv), .rxEr(dpEr),
    .crs(dpCrs), .col(dpCol), .txd(txd), .txEn(txEn), .txEr(txEr),
    .lineTxValid(dpTxValid), .lineTxByte(dpTxByte), .lineTxErr(dpTxErr)
  );

  // isolation gate: nothing leaves until the reset window is over
  always_comb begin
    miiOe       = strobe.live;
    lineTxEn    = strobe.live;
    lineRxTake  = strobe.live & dpTake;
    rxd         = strobe.live ? dpRxd : '0;
    rxDv        = strobe.live & dpDv;
    rxEr        = strobe.live & dpEr;
    crs         = strobe.live & dpCrs;
    col         = strobe.live & dpCol;
    lineTxValid = strobe.live & dpTxValid;
    lineTxByte  = strobe.live ? dpTxByte : '0;
    lineTxErr   = strobe.live & dpTxErr;
  end
endmodule

// File: rtl/mii_port_chk.sv
module mii_port_chk (
  input logic clk,
  input logic rst_n,
  input logic fullDuplex,
  input logic miiOe,
  input logic lineTxEn,
  input logic crs,
  input logic col,
  input logic rxDv,
  input logic rxEr,
  input logic lineTxValid
);
  // R1: isolated outputs stay quiet
  p_iso_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !miiOe |-> (!crs && !col && !rxDv && !lineTxValid));
  // R1: once enabled, outputs stay enabled until the next reset
  p_oe_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    miiOe |=> (miiOe && lineTxEn));
  // R3: an error nibble is always inside a valid frame
  p_er_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rxEr |-> rxDv);
  // R4: a rebuilt byte needs two nibble slots, so strobes never abut
  p_tx_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lineTxValid |=> !lineTxValid);
  // R7: a collision always comes with carrier
  p_col_has_crs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    col |-> crs);
  // R8: in full duplex, carrier needs receive activity
  p_fd_crs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fullDuplex && !rxDv) |-> !crs);
  // R9: no collision in full duplex
  p_fd_col_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fullDuplex |-> !col);
endmodule

bind mii_port_top mii_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fullDuplex(fullDuplex), .miiOe(miiOe),
  .lineTxEn(lineTxEn), .crs(crs), .col(col), .rxDv(rxDv), .rxEr(rxEr),
  .lineTxValid(lineTxValid)
);

// File: tb/tb_mii_port_top.sv
module tb_mii_port_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nibEn = 1'b0, speed100 = 1'b1, fullDuplex = 1'b0;
  logic       lineRxValid = 1'b0, lineRxErr = 1'b0;
  logic [7:0] lineRxByte = 8'h00;
  logic       lineRxTake;
  logic [3:0] rxd;
  logic       rxDv, rxEr, crs, col, miiOe;
  logic [3:0] txd = 4'h0;
  logic       txEn = 1'b0, txEr = 1'b0;
  logic       lineTxEn, lineTxValid, lineTxErr;
  logic [7:0] lineTxByte;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  mii_port_top dut (
    .clk(clk), .rst_n(rst_n), .nibEn(nibEn), .speed100(speed100),
    .fullDuplex(fullDuplex), .lineRxValid(lineRxValid), .lineRxByte(lineRxByte),
    .lineRxErr(lineRxErr), .lineRxTake(lineRxTake), .rxd(rxd), .rxDv(rxDv),
    .rxEr(rxEr), .crs(crs), .col(col), .miiOe(miiOe), .txd(txd), .txEn(txEn),
    .txEr(txEr), .lineTxEn(lineTxEn), .lineTxValid(lineTxValid),
    .lineTxByte(lineTxByte), .lineTxErr(lineTxErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {fullDuplex, txEn, rxValid, expCrs, expCol}
  localparam logic [4:0] VEC [8] = '{
    5'b000_00, 5'b010_10, 5'b001_10, 5'b011_11,
    5'b100_00, 5'b110_00, 5'b101_10, 5'b111_10
  };

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state
    nibEn = 1'b1; txEn = 1'b1; txd = 4'h3; lineRxValid = 1'b1; lineRxByte = 8'hFF;
    repeat (3) step();
    chk("R1 reset miiOe", {31'b0, miiOe}, 32'd0);
    chk("R1 reset lineTxEn", {31'b0, lineTxEn}, 32'd0);

    // R1: window of 8 enable pulses with activity on every input
    rst_n = 1'b1;
    for (int i = 1; i <= 7; i++) begin
      step();
      chk("R1 window quiet", {24'b0, rxd, rxDv, rxEr, crs, col},
          32'd0);
      chk("R1 window oe", {30'b0, miiOe, lineTxEn | lineTxValid}, 32'd0);
    end
    step();
    chk("R1 enabled after window", {30'b0, miiOe, lineTxEn}, 32'd3);
    txEn = 1'b0; lineRxValid = 1'b0;
    repeat (2) step();

    // table: duplex x tx x rx, each held for two byte times
    foreach (VEC[k]) begin
      fullDuplex = VEC[k][4]; txEn = VEC[k][3]; lineRxValid = VEC[k][2];
      lineRxByte = 8'h5A;
      repeat (4) step();
      if (!VEC[k][4]) begin
        chk("R6 half crs", {31'b0, crs}, {31'b0, VEC[k][1]});
        chk("R7 half col", {31'b0, col}, {31'b0, VEC[k][0]});
      end else begin
        chk("R8 full crs", {31'b0, crs}, {31'b0, VEC[k][1]});
        chk("R9 full col", {31'b0, col}, {31'b0, VEC[k][0]});
      end
    end
    fullDuplex = 1'b0; txEn = 1'b0; lineRxValid = 1'b0;
    repeat (2) step();

    // R2/R3: nibble order, error marking, valid edges
    lineRxValid = 1'b1; lineRxByte = 8'hA5; lineRxErr = 1'b0;
    step();
    chk("R2 first nibble low", {26'b0, rxd, rxDv, rxEr}, {26'b0, 4'h5, 1'b1, 1'b0});
    lineRxByte = 8'h3C; lineRxErr = 1'b1;
    step();
    chk("R2 second nibble high", {26'b0, rxd, rxDv, rxEr}, {26'b0, 4'hA, 1'b1, 1'b0});
    step();
    chk("R3 error low nibble", {26'b0, rxd, rxDv, rxEr}, {26'b0, 4'hC, 1'b1, 1'b1});
    lineRxValid = 1'b0; lineRxErr = 1'b0;
    step();
    chk("R3 error high nibble", {26'b0, rxd, rxDv, rxEr}, {26'b0, 4'h3, 1'b1, 1'b1});
    step();
    chk("R2 rxDv falls", {30'b0, rxDv, rxEr}, 32'd0);

    // R4/R5: transmit rebuild
    txEn = 1'b1; txd = 4'h6; txEr = 1'b0;
    step();
    chk("R4 no strobe after first nibble", {31'b0, lineTxValid}, 32'd0);
    txd = 4'h9; txEr = 1'b1;
    step();
    chk("R4 rebuilt byte", {23'b0, lineTxValid, lineTxByte}, {23'b0, 1'b1, 8'h96});
    chk("R5 error on second nibble", {31'b0, lineTxErr}, 32'd1);
    txd = 4'hE; txEr = 1'b0;
    step();
    chk("R4 strobe one clock", {31'b0, lineTxValid}, 32'd0);
    txd = 4'h2;
    step();
    chk("R4 clean byte", {23'b0, lineTxValid, lineTxByte}, {23'b0, 1'b1, 8'h2E});
    chk("R5 clean byte no error", {31'b0, lineTxErr}, 32'd0);
    txEn = 1'b0;
    repeat (2) step();

    // R10: 10 Mb/s divides the enable by 10
    speed100 = 1'b0; lineRxValid = 1'b1; lineRxByte = 8'h7B;
    repeat (9) step();
    chk("R10 no nibble before 10th pulse", {31'b0, rxDv}, 32'd0);
    step();
    chk("R10 nibble at 10th pulse", {27'b0, rxDv, rxd}, {27'b0, 1'b1, 4'hB});
    lineRxValid = 1'b0; speed100 = 1'b1;
    repeat (3) step();
    chk("R10 back to 100 idle", {31'b0, rxDv}, 32'd0);

    // R1: second reset isolates again
    txEn = 1'b1; lineRxValid = 1'b1;
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 re-isolated", {28'b0, miiOe, crs, col, rxDv}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule